// File: doc/BRIEF.md
# Two-Bank DRAM Command Decoder and Protocol Monitor

This block sits on the device side of a two-bank synchronous DRAM command bus. On every rising clock edge it samples clock-enable, the four active-low strobes (chip select, row strobe, column strobe, write enable), the bank select and the 11-bit address. From these it names the command. It tracks whether each bank is open and which row is open in it, and it captures mode register writes. It also remembers the column of the most recent read or write.

Any command that breaks the ordering rules raises a sticky violation flag and bumps an error counter. An illegal command changes no bank state.

All outputs are registered. They show the effect of the edge at which the command was sampled. The memory array, data timing and electrical behaviour are not modelled.

Top module: `dram_cmd_monitor`

## Requirements
- R1: When clock-enable was high at the previous edge, the command is decoded onto `cmd_code`:
  - chip select high gives NOP (0), whatever the other strobes are.
  - With chip select low, {ras_n,cas_n,we_n} decode as follows:
    - 111 gives NOP (0).
    - 110 gives burst stop (1).
    - 101 gives read (2), or read with auto-precharge (3) when addr[10] is high.
    - 100 gives write (4), or write with auto-precharge (5) when addr[10] is high.
    - 011 gives activate (6).
    - 010 gives precharge (7), or precharge-all (8) when addr[10] is high.
    - 000 gives mode set (9).
    - 001 gives the undecoded code (11), which has no effect.
- R2: When clock-enable was low at the previous edge, `cmd_code` reads 10 (suspended). The sampled command then has no effect on any state.
- R3: A legal activate opens the bank given by `ba` and latches addr[10:0] as its row. Bank b's row appears at `open_rows[b*11 +: 11]`, and `bank_open[b]` is 1 while bank b is open.
- R4: A read or write, with or without auto-precharge, to a closed bank sets `viol_flags[0]`.
- R5: An activate to a bank that is already open sets `viol_flags[1]` and leaves that bank's row unchanged.
- R6: A mode set while either bank is open sets `viol_flags[2]` and leaves `mode_val` unchanged. A mode set with both banks closed copies addr[10:0] into `mode_val`.
- R7: A legal read or write with auto-precharge leaves its bank open for one more cycle. The bank reads closed after the following edge.
- R8: A single precharge closes only the bank given by `ba`, and it is legal on a bank that is already closed. Precharge-all closes both banks.
- R9: Violation flags stay set until `clr_viol` is sampled high. That clear also zeroes `err_cnt`. A violation sampled at the same edge as a clear survives the clear.
- R10: `err_cnt` rises by exactly one for each illegal command and saturates at its maximum.
- R11: Every read or write, legal or not, copies addr[7:0] into `last_col`.
- R12: During reset, `cmd_code` is 0 and all bank, row, mode, column, flag and counter outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable as sampled from the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| addr | input | 11 | Address; bit 10 selects auto-precharge or all banks |
| clr_viol | input | 1 | Clears violation flags and error counter |
| cmd_code | output | 4 | Decoded command of the last edge |
| bank_open | output | 2 | Open state per bank |
| open_rows | output | 22 | Open row per bank, 11 bits each |
| last_col | output | 8 | Column of the latest read or write |
| mode_val | output | 11 | Captured mode value |
| viol_flags | output | 3 | Sticky flags: closed access, double activate, busy mode set |
| err_cnt | output | 8 | Count of illegal commands |

## Verification
The assertions take for granted that `ba` and `addr` carry defined values on every edge. They also take for granted that `clr_viol` is a plain level sampled at the edge, so a flag may drop only at an edge where the clear was high.

The stimulus drives every input a short time after the falling edge and holds it through the rising edge. Clock-enable is kept low through reset and during the synchronizer's release cycles, so no command falls inside the release window.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_BST  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WR   = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_ACT  = 4'd6,
    CMD_PRE  = 4'd7,
    CMD_PALL = 4'd8,
    CMD_MRS  = 4'd9,
    CMD_SUSP = 4'd10,
    CMD_UNK  = 4'd11
  } cmd_e;

  localparam int VIOL_W      = 3;
  localparam int V_CLOSED    = 0;
  localparam int V_DOUBLEACT = 1;
  localparam int V_BUSYMODE  = 2;

  function automatic logic is_access(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
  endfunction
endpackage

// File: rtl/dcm_decode.sv
module dcm_decode
  import dcm_pkg::*;
(
  input  logic cke_q,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic ap,
  output cmd_e cmd
);
  always_comb begin
    cmd = CMD_NOP;
    if (!cke_q) begin
      cmd = CMD_SUSP;
    end else if (!cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: cmd = CMD_NOP;
        3'b110: cmd = CMD_BST;
        3'b101: cmd = ap ? CMD_RDA : CMD_RD;
        3'b100: cmd = ap ? CMD_WRA : CMD_WR;
        3'b011: cmd = CMD_ACT;
        3'b010: cmd = ap ? CMD_PALL : CMD_PRE;
        3'b000: cmd = CMD_MRS;
        default: cmd = CMD_UNK;
      endcase
    end
  end
endmodule

// File: rtl/dcm_bank.sv
module dcm_bank
  import dcm_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  cmd_e             cmd,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row
);
  logic             open_n;
  logic             pend_q;
  logic             pend_n;
  logic [ROW_W-1:0] row_n;
  logic             row_en;

  always_comb begin
    open_n = is_open;
    pend_n = 1'b0;
    row_n  = row;
    row_en = 1'b0;
    if (pend_q) open_n = 1'b0;
    unique case (cmd)
      CMD_ACT: if (hit && !is_open) begin
        open_n = 1'b1;
        row_n  = row_in;
        row_en = 1'b1;
      end
      CMD_RDA, CMD_WRA: if (hit && is_open && !pend_q) pend_n = 1'b1;
      CMD_PRE: if (hit) open_n = 1'b0;
      CMD_PALL: open_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      pend_q  <= 1'b0;
      row     <= '0;
    end else begin
      is_open <= open_n;
      pend_q  <= pend_n;
      if (row_en) row <= row_n;
    end
  end
endmodule

// File: rtl/dcm_viol.sv
module dcm_viol
  import dcm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [VIOL_W-1:0] new_viol,
  output logic [VIOL_W-1:0] flags,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [VIOL_W-1:0] flags_n;
  logic [CNT_W-1:0]  cnt_n;
  logic [CNT_W-1:0]  cnt_base;

  always_comb begin
    flags_n  = (clr ? '0 : flags) | new_viol;
    cnt_base = clr ? '0 : cnt;
    cnt_n    = cnt_base;
    if ((|new_viol) && (cnt_base != CNT_MAX)) cnt_n = cnt_base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      cnt   <= '0;
    end else begin
      flags <= flags_n;
      cnt   <= cnt_n;
    end
  end
endmodule

// File: rtl/dram_cmd_monitor.sv
module dram_cmd_monitor
  import dcm_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int ROW_W = 11,
  parameter int COL_W = 8,
  parameter int CNT_W = 8,
  localparam int BA_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int AP_BIT = ROW_W - 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  input  logic                   clr_viol,
  output logic [3:0]             cmd_code,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_rows,
  output logic [COL_W-1:0]       last_col,
  output logic [ROW_W-1:0]       mode_val,
  output logic [VIOL_W-1:0]      viol_flags,
  output logic [CNT_W-1:0]       err_cnt
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  logic cke_q;
  cmd_e cmd;

  dcm_decode u_dec (
    .cke_q (cke_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ap    (addr[AP_BIT]),
    .cmd   (cmd)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dcm_bank #(.ROW_W(ROW_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .hit     (ba == BA_W'(b)),
      .cmd     (cmd),
      .row_in  (addr),
      .is_open (bank_open[b]),
      .row     (open_rows[b*ROW_W +: ROW_W])
    );
  end

  logic [VIOL_W-1:0] new_viol;
  logic              tgt_open;

  always_comb begin
    tgt_open = bank_open[ba];
    new_viol = '0;
    new_viol[V_CLOSED]    = is_access(cmd) && !tgt_open;
    new_viol[V_DOUBLEACT] = (cmd == CMD_ACT) && tgt_open;
    new_viol[V_BUSYMODE]  = (cmd == CMD_MRS) && (|bank_open);
  end

  dcm_viol #(.CNT_W(CNT_W)) u_viol (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (clr_viol),
    .new_viol (new_viol),
    .flags    (viol_flags),
    .cnt      (err_cnt)
  );

  logic mode_en;
  logic col_en;

  always_comb begin
    mode_en = (cmd == CMD_MRS) && !(|bank_open);
    col_en  = is_access(cmd);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cke_q    <= 1'b0;
      cmd_code <= 4'(CMD_NOP);
      mode_val <= '0;
      last_col <= '0;
    end else begin
      cke_q    <= cke;
      cmd_code <= 4'(cmd);
      if (mode_en) mode_val <= addr;
      if (col_en)  last_col <= addr[COL_W-1:0];
    end
  end
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker
  import dcm_pkg::*;
#(
  parameter int NBANK = 2,
  parameter int CNT_W = 8,
  parameter int ROW_W = 11,
  parameter int BA_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BA_W-1:0]   ba,
  input logic              clr_viol,
  input logic [3:0]        cmd_code,
  input logic [NBANK-1:0]  bank_open,
  input logic [VIOL_W-1:0] viol_flags,
  input logic [CNT_W-1:0]  err_cnt,
  input logic [ROW_W-1:0]  mode_val
);
  logic [BA_W-1:0]  ba_q;
  logic [NBANK-1:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q   <= '0;
      open_q <= '0;
    end else begin
      ba_q   <= ba;
      open_q <= bank_open;
    end
  end

  // R4
  closed_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code >= 4'd2) && (cmd_code <= 4'd5) && !open_q[ba_q]) |-> viol_flags[V_CLOSED]);

  // R6
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == 4'd9) && (|open_q)) |-> viol_flags[V_BUSYMODE]);

  // R8
  pall_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd8) |-> (bank_open == '0));

  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_viol |=> ((viol_flags & $past(viol_flags)) == $past(viol_flags)));

  // R10
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_viol |=> (err_cnt >= $past(err_cnt)));

  // R2
  susp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd10) |-> $stable(mode_val));
endmodule

bind dram_cmd_monitor dcm_checker #(
  .NBANK(NBANK), .CNT_W(CNT_W), .ROW_W(ROW_W), .BA_W(BA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ba         (ba),
  .clr_viol   (clr_viol),
  .cmd_code   (cmd_code),
  .bank_open  (bank_open),
  .viol_flags (viol_flags),
  .err_cnt    (err_cnt),
  .mode_val   (mode_val)
);

// File: tb/tb_dram_cmd_monitor.sv
module tb_dram_cmd_monitor;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n, clr_viol;
  logic [0:0]  ba;
  logic [10:0] addr;
  logic [3:0]  cmd_code;
  logic [1:0]  bank_open;
  logic [21:0] open_rows;
  logic [7:0]  last_col;
  logic [10:0] mode_val;
  logic [2:0]  viol_flags;
  logic [7:0]  err_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cmd_monitor dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .clr_viol(clr_viol),
    .cmd_code(cmd_code), .bank_open(bank_open), .open_rows(open_rows),
    .last_col(last_col), .mode_val(mode_val), .viol_flags(viol_flags),
    .err_cnt(err_cnt)
  );

  typedef struct {
    logic [3:0]  code;
    logic [1:0]  opn;
    logic [21:0] rows;
    logic [7:0]  col;
    logic [10:0] mode;
    logic [2:0]  flags;
    logic [7:0]  cnt;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state, kept from the requirements
  logic        m_cke;
  logic [1:0]  m_open, m_pend;
  logic [10:0] m_row [2];
  logic [7:0]  m_col;
  logic [10:0] m_mode;
  logic [2:0]  m_flags;
  logic [7:0]  m_cnt;

  task automatic compare(input exp_t e);
    n_chk++;
    if (cmd_code !== e.code || bank_open !== e.opn || open_rows !== e.rows ||
        last_col !== e.col || mode_val !== e.mode || viol_flags !== e.flags ||
        err_cnt !== e.cnt) begin
      n_fail++;
      $display("FAIL %s: got code=%0d open=%b rows=%h col=%h mode=%h flags=%b cnt=%0d exp code=%0d open=%b rows=%h col=%h mode=%h flags=%b cnt=%0d",
        e.tag, cmd_code, bank_open, open_rows, last_col, mode_val, viol_flags, err_cnt,
        e.code, e.opn, e.rows, e.col, e.mode, e.flags, e.cnt);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(input logic ck, input logic [3:0] strobes, input logic b,
                      input logic [10:0] a, input logic clr, input string tag);
    logic [3:0] c;
    logic [2:0] nv;
    logic [1:0] open_n, pend_n;
    logic [21:0] rows;
    exp_t e;
    @(negedge clk);
    #1;
    cke = ck; {cs_n, ras_n, cas_n, we_n} = strobes; ba = b; addr = a; clr_viol = clr;
    if (!m_cke) c = 4'd10;
    else if (strobes[3]) c = 4'd0;
    else case (strobes[2:0])
      3'b111: c = 4'd0;
      3'b110: c = 4'd1;
      3'b101: c = a[10] ? 4'd3 : 4'd2;
      3'b100: c = a[10] ? 4'd5 : 4'd4;
      3'b011: c = 4'd6;
      3'b010: c = a[10] ? 4'd8 : 4'd7;
      3'b000: c = 4'd9;
      default: c = 4'd11;
    endcase
    nv = 3'b000;
    if (c >= 4'd2 && c <= 4'd5 && !m_open[b]) nv[0] = 1'b1;
    if (c == 4'd6 && m_open[b]) nv[1] = 1'b1;
    if (c == 4'd9 && (|m_open)) nv[2] = 1'b1;
    open_n = m_open & ~m_pend;
    pend_n = 2'b00;
    if (c == 4'd6 && !m_open[b]) begin open_n[b] = 1'b1; m_row[b] = a; end
    if ((c == 4'd3 || c == 4'd5) && m_open[b] && !m_pend[b]) pend_n[b] = 1'b1;
    if (c == 4'd7) open_n[b] = 1'b0;
    if (c == 4'd8) open_n = 2'b00;
    if (c == 4'd9 && !(|m_open)) m_mode = a;
    if (c >= 4'd2 && c <= 4'd5) m_col = a[7:0];
    m_flags = (clr ? 3'b000 : m_flags) | nv;
    if (clr) m_cnt = 8'd0;
    if ((|nv) && m_cnt != 8'hFF) m_cnt = m_cnt + 8'd1;
    m_open = open_n; m_pend = pend_n; m_cke = ck;
    rows = {m_row[1], m_row[0]};
    e = '{code: c, opn: m_open, rows: rows, col: m_col, mode: m_mode,
          flags: m_flags, cnt: m_cnt, tag: tag};
    q.push_back(e);
  endtask

  // strobe encodings {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] S_DESL = 4'b1000;
  localparam logic [3:0] S_NOP  = 4'b0111;
  localparam logic [3:0] S_BST  = 4'b0110;
  localparam logic [3:0] S_RD   = 4'b0101;
  localparam logic [3:0] S_WR   = 4'b0100;
  localparam logic [3:0] S_ACT  = 4'b0011;
  localparam logic [3:0] S_PRE  = 4'b0010;
  localparam logic [3:0] S_MRS  = 4'b0000;
  localparam logic [3:0] S_REF  = 4'b0001;

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got running exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    rst_n = 1'b0; cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = S_NOP;
    ba = 1'b0; addr = '0; clr_viol = 1'b0;
    m_cke = 1'b0; m_open = '0; m_pend = '0; m_row[0] = '0; m_row[1] = '0;
    m_col = '0; m_mode = '0; m_flags = '0; m_cnt = '0;
    repeat (2) @(negedge clk);
    // R12 reset state
    e0 = '{code: 4'd0, opn: 2'b00, rows: 22'd0, col: 8'd0, mode: 11'd0,
           flags: 3'b000, cnt: 8'd0, tag: "R12 reset"};
    compare(e0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    step(1, S_ACT, 0, 11'h5A3, 0, "R2 suspended after low cke");
    step(1, S_ACT, 0, 11'h5A3, 0, "R3 activate bank0");
    step(1, S_RD,  0, 11'h012, 0, "R1 R11 read bank0");
    step(1, S_RD,  1, 11'h034, 0, "R4 read closed bank1");
    step(1, S_ACT, 0, 11'h111, 0, "R5 activate open bank0");
    step(1, S_ACT, 1, 11'h7FF, 0, "R3 activate bank1");
    step(1, S_MRS, 0, 11'h2AB, 0, "R6 mode set busy");
    step(1, S_DESL,0, 11'h000, 0, "R1 deselect as nop");
    step(1, S_BST, 0, 11'h000, 0, "R1 burst stop");
    step(1, S_WR,  1, 11'h0C5, 0, "R1 R11 write bank1");
    step(1, S_WR,  0, 11'h4EE, 0, "R7 write autoprecharge bank0");
    step(1, S_NOP, 0, 11'h000, 0, "R7 bank0 closes");
    step(1, S_PRE, 0, 11'h000, 0, "R8 precharge idle bank0");
    step(1, S_NOP, 0, 11'h000, 1, "R9 clear flags");
    step(1, S_WR,  0, 11'h056, 1, "R9 violation during clear");
    step(1, S_PRE, 0, 11'h400, 0, "R8 precharge all");
    step(1, S_MRS, 1, 11'h123, 0, "R6 mode set idle");
    step(0, S_NOP, 0, 11'h000, 0, "R1 nop with cke dropping");
    step(1, S_ACT, 1, 11'h0AA, 0, "R2 activate suspended");
    step(1, S_ACT, 1, 11'h0AA, 0, "R3 activate bank1 again");
    step(1, S_RD,  1, 11'h477, 0, "R7 read autoprecharge bank1");
    step(1, S_ACT, 1, 11'h0BB, 0, "R5 R7 activate while closing");
    step(1, S_REF, 0, 11'h000, 0, "R1 undecoded");
    step(1, S_ACT, 0, 11'h321, 0, "R3 activate bank0");
    step(1, S_PRE, 1, 11'h000, 0, "R8 single precharge bank1 only");
    for (int i = 0; i < 260; i++)
      step(1, S_ACT, 0, 11'h001, 0, "R10 repeated violations saturate");
    step(1, S_NOP, 0, 11'h000, 0, "R10 saturated hold");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule